// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block produces a single output pulse of fixed length each time an active-low trigger input falls. The length is not counted in system clocks but in rising edges of a slow, free-running external time-base (nominally 50 Hz, so one tick is 20 ms). The length is set at build time: a period in milliseconds divided by the tick length in milliseconds gives the terminal count. With the default of 18.5 s and 20 ms ticks this is 925 ticks.

A level-sensitive mode input decides what a trigger does while a pulse is running. In retriggerable mode the running count restarts from zero, which stretches the pulse. In non-retriggerable mode the trigger is ignored and the pulse ends on schedule. The block has a control FSM with an idle and a timing state, and a counting datapath that is held at zero while idle. All three inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser before edge detection.

The block carries no data stream, so it has no valid/ready interface. Every pin is a plain control or status level.

Top module: `oneshot_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces the idle state and a zero count and drives `pulse_out` low. A pulse in progress is cut short. The synchroniser flops reset to the inactive levels: trigger high, time-base low and mode low.
- R2: A falling edge on `trig_n` while idle raises `pulse_out`. A change that is driven between clock edges is seen at the output after the third following rising clock edge: two synchroniser stages, then the edge register and the state register. A rising edge on `trig_n` starts nothing.
- R3: Only rising edges of `tbase` advance the count. A high or low level held for any length counts once at most. `pulse_out` falls at the rising tick that completes the terminal count of ticks after the most recent (re)start.
- R4: The terminal count is `PERIOD_MS / TICK_MS`. This is 925 for the defaults of 18500 and 20. The count never reaches this value.
- R5: With `rt_mode` high (1 = retriggerable), a falling trigger edge during timing clears the count to zero and keeps `pulse_out` high. A full period then runs from that edge.
- R6: With `rt_mode` low (0 = non-retriggerable), a falling trigger edge during timing has no effect. The pulse ends at the same tick as without the edge.
- R7: `rt_mode` is used as a synchronised level at the moment a trigger edge is seen. Changing it in the middle of a pulse governs the triggers that follow the change.
- R8: While idle, `tbase` ticks have no effect. The output stays low and the next pulse still lasts the full terminal count.
- R9: If a retriggering trigger edge and a tick are seen in the same clock cycle, the restart wins and the tick is not counted.
- R10: After a pulse ends, the next falling trigger edge starts a new pulse of full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_n | input | 1 | Asynchronous trigger, active-low; a falling edge starts or restarts the pulse |
| tbase | input | 1 | Asynchronous slow time-base; each rising edge is one tick |
| rt_mode | input | 1 | Asynchronous mode level: 1 = retriggerable, 0 = non-retriggerable |
| pulse_out | output | 1 | High exactly while the timer is in the timing state |

## Verification
The hardest situation to reach from the ports is a trigger edge and a time-base edge landing in the same clock cycle, because both pass through independent synchronisers and edge registers. The stimulus drives both inputs at the same falling clock edge so that their pipelines line up exactly. It does this both in the middle of a period and with the count near the end. Changing the mode between a start and a retrigger checks that the mode is read as a live level rather than latched at the start.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic {
    OS_IDLE = 1'b0,
    OS_TIME = 1'b1
  } os_state_e;

  // bit positions of the synchronised input vector
  localparam int unsigned IN_TRIG = 0;
  localparam int unsigned IN_TICK = 1;
  localparam int unsigned IN_MODE = 2;
  localparam int unsigned IN_W    = 3;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned     W       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[LAST];
  end

endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge #(
  parameter int unsigned  W         = 2,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter logic [W-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] evt
);

  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  for (genvar b = 0; b < W; b++) begin : g_det
    if (FALL_MASK[b]) begin : g_fall
      assign evt[b] = prev[b] & ~lvl[b];
    end else begin : g_rise
      assign evt[b] = ~prev[b] & lvl[b];
    end
  end

endmodule

// File: rtl/oneshot_count.sv
module oneshot_count #(
  parameter int unsigned TERM = 925,
  parameter int unsigned CW   = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          at_last
);

  localparam logic [CW-1:0] LAST_V = CW'(TERM - 1);

  assign at_last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (adv)     cnt <= at_last ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      trg,
  input  logic      tick,
  input  logic      retrig_ok,
  input  logic      at_last,
  output os_state_e state,
  output logic      clr,
  output logic      adv
);

  os_state_e nxt;
  logic      restart;

  assign restart = trg & retrig_ok;

  always_comb begin
    nxt = state;
    clr = 1'b0;
    adv = 1'b0;
    unique case (state)
      OS_IDLE: begin
        clr = 1'b1;
        if (trg) nxt = OS_TIME;
      end
      OS_TIME: begin
        if (restart) begin
          clr = 1'b1;
        end else if (tick) begin
          adv = 1'b1;
          if (at_last) nxt = OS_IDLE;
        end
      end
      default: nxt = OS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= OS_IDLE;
    else     state <= nxt;
  end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned PERIOD_MS = 18500,
  parameter int unsigned TICK_MS   = 20,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_n,
  input  logic tbase,
  input  logic rt_mode,
  output logic pulse_out
);

  localparam int unsigned TERM = PERIOD_MS / TICK_MS;
  localparam int unsigned CW   = $clog2(TERM + 1);
  localparam logic [IN_W-1:0] SYNC_RST = IN_W'(1) << IN_TRIG;

  logic [IN_W-1:0] raw_in, syn;
  logic [1:0]      evt;
  logic            trg_fall, tb_rise, rt_lvl;
  logic [CW-1:0]   cnt_q;
  logic            at_last, clr, adv;
  os_state_e       state;

  always_comb begin
    raw_in          = '0;
    raw_in[IN_TRIG] = trig_n;
    raw_in[IN_TICK] = tbase;
    raw_in[IN_MODE] = rt_mode;
  end

  oneshot_sync #(.W(IN_W), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_in), .q_sync(syn)
  );

  oneshot_edge #(.W(2), .RST_VAL(2'b01), .FALL_MASK(2'b01)) u_edge (
    .clk(clk), .rst(rst), .lvl({syn[IN_TICK], syn[IN_TRIG]}), .evt(evt)
  );

  assign trg_fall = evt[0];
  assign tb_rise  = evt[1];
  assign rt_lvl   = syn[IN_MODE];

  oneshot_ctrl u_ctrl (
    .clk(clk), .rst(rst), .trg(trg_fall), .tick(tb_rise), .retrig_ok(rt_lvl),
    .at_last(at_last), .state(state), .clr(clr), .adv(adv)
  );

  oneshot_count #(.TERM(TERM), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv), .cnt(cnt_q), .at_last(at_last)
  );

  assign pulse_out = (state == OS_TIME);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(TERM));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (state == OS_IDLE) |-> (cnt_q == '0));

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (state == OS_IDLE && trg_fall) |=> (pulse_out && cnt_q == '0));

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == OS_IDLE && !trg_fall) |=> !pulse_out);

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (state == OS_TIME && rt_lvl && trg_fall) |=> (pulse_out && cnt_q == '0));

  p_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (state == OS_TIME && !rt_lvl && trg_fall && !tb_rise) |=>
      (pulse_out && cnt_q == $past(cnt_q)));

  p_end_r3: assert property (@(posedge clk) disable iff (rst)
    (state == OS_TIME && tb_rise && at_last && !(rt_lvl && trg_fall)) |=> !pulse_out);

endmodule

// File: tb/test_oneshot_timer.sv
module test_oneshot_timer;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned P_MS = 200;
  localparam int unsigned T_MS = 20;
  localparam int TERM = P_MS / T_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_n = 1'b1;
  logic tbase = 1'b0;
  logic rt_mode = 1'b0;
  logic pulse_out;

  always #2.5 clk = ~clk;

  oneshot_timer #(.PERIOD_MS(P_MS), .TICK_MS(T_MS)) i_oneshot_timer (
    .clk(clk), .rst(rst), .trig_n(trig_n), .tbase(tbase),
    .rt_mode(rt_mode), .pulse_out(pulse_out)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference: input histories of the last three edges
  int m_busy = 0, m_cnt = 0;
  int th0 = 1, th1 = 1, th2 = 1;
  int bh0 = 0, bh1 = 0, bh2 = 0;
  int rh0 = 0, rh1 = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cnt = 0;
      th0 = 1; th1 = 1; th2 = 1;
      bh0 = 0; bh1 = 0; bh2 = 0;
      rh0 = 0; rh1 = 0;
    end else begin
      bit f, tk, r;
      f  = (th2 == 1) && (th1 == 0);
      tk = (bh2 == 0) && (bh1 == 1);
      r  = (rh1 == 1);
      if (m_busy == 0) begin
        if (f) begin m_busy = 1; m_cnt = 0; end
      end else if (f && r) begin
        m_cnt = 0;
      end else if (tk) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == TERM) begin m_busy = 0; m_cnt = 0; end
      end
      th2 = th1; th1 = th0; th0 = int'(trig_n);
      bh2 = bh1; bh1 = bh0; bh0 = int'(tbase);
      rh1 = rh0; rh0 = int'(rt_mode);
    end
  end

  always @(negedge clk) begin
    if (!done && cyc > 2) begin
      total++;
      if (int'(pulse_out) != m_busy) begin
        bad++;
        $display("FAIL %s model compare at cycle %0d: pulse_out=%0d expected=%0d",
                 cur_req, cyc, pulse_out, m_busy);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog expired at cycle %0d: done=0 expected=1", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s directed: pulse_out=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tbase = 1'b1; wait_n(3);
      tbase = 1'b0; wait_n(3);
    end
  endtask

  task automatic fire();
    trig_n = 1'b0; wait_n(4);
    trig_n = 1'b1; wait_n(4);
  endtask

  initial begin
    wait_n(4);
    chk("R1", pulse_out, 1'b0);
    rst = 1'b0;
    wait_n(2);

    cur_req = "R8";
    tick(3);
    chk("R8", pulse_out, 1'b0);

    cur_req = "R2";
    trig_n = 1'b0;
    wait_n(2); chk("R2", pulse_out, 1'b0);
    wait_n(1); chk("R2", pulse_out, 1'b1);
    wait_n(3); trig_n = 1'b1; wait_n(5);
    chk("R2", pulse_out, 1'b1);

    cur_req = "R3";
    tick(TERM - 1); chk("R3", pulse_out, 1'b1);
    tbase = 1'b1; wait_n(40); chk("R3", pulse_out, 1'b0);
    tbase = 1'b0; wait_n(6);
    chk("R8", pulse_out, 1'b0);

    cur_req = "R10";
    fire(); tick(TERM - 1); chk("R10", pulse_out, 1'b1);
    tick(1); chk("R10", pulse_out, 1'b0);

    cur_req = "R6";
    rt_mode = 1'b0; wait_n(4);
    fire(); tick(4); fire(); tick(TERM - 5);
    chk("R6", pulse_out, 1'b1);
    tick(1); chk("R6", pulse_out, 1'b0);

    cur_req = "R5";
    rt_mode = 1'b1; wait_n(4);
    fire(); tick(4); fire(); tick(TERM - 1);
    chk("R5", pulse_out, 1'b1);
    tick(1); chk("R5", pulse_out, 1'b0);

    cur_req = "R7";
    rt_mode = 1'b0; wait_n(4);
    fire(); tick(3);
    rt_mode = 1'b1; wait_n(4);
    fire(); tick(TERM - 1);
    chk("R7", pulse_out, 1'b1);
    tick(1); chk("R7", pulse_out, 1'b0);

    cur_req = "R9";
    fire(); tick(5);
    trig_n = 1'b0; tbase = 1'b1; wait_n(3);
    trig_n = 1'b1; tbase = 1'b0; wait_n(3);
    tick(TERM - 1); chk("R9", pulse_out, 1'b1);
    tick(1); chk("R9", pulse_out, 1'b0);

    fire(); tick(TERM - 2);
    trig_n = 1'b0; tbase = 1'b1; wait_n(3);
    trig_n = 1'b1; tbase = 1'b0; wait_n(3);
    tick(TERM - 1); chk("R9", pulse_out, 1'b1);
    tick(1); chk("R9", pulse_out, 1'b0);

    cur_req = "R1";
    fire(); tick(2); chk("R1", pulse_out, 1'b1);
    rst = 1'b1; wait_n(2); chk("R1", pulse_out, 1'b0);
    rst = 1'b0; wait_n(2);
    tick(TERM + 2); chk("R1", pulse_out, 1'b0);

    wait_n(4);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule